// File: doc/BRIEF.md
# Auto-Reload Update Timer

This block is a small up-counting timer with a register interface. A prescaler divides the core clock by a programmable amount and produces count ticks. On each tick the counter goes up by one. When the counter is already at the active reload value, the tick wraps it back to zero instead. That wrap is the update event: it raises a one-cycle pulse on a dedicated output and sets a sticky flag that software can read and clear.

Software controls the timer through six word registers: control, status, reload, prescale, counter and command. Two reload styles are available. In the direct style a newly written reload limit takes effect at once. In the buffered style it waits in a holding register until the next update event. The prescale divider is always loaded at an update event.

A one-pulse setting makes the timer disable itself at the first wrap. A command write forces an update event and restarts the count. A debug-halt input stalls counting whenever the freeze option is selected.

Top module: `upd_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, the counter is 0, and both `upd_pulse` and `upd_flag` are low.
- R2: Register addresses are 0 control, 1 status, 2 reload, 3 prescale, 4 counter and 5 command. Control bit 0 enables counting, bit 1 selects freeze-on-halt, bit 3 selects one-pulse and bit 7 selects the buffered reload. All other control bits read 0 and ignore writes, and unmapped addresses read 0.
- R3: With an active prescale value P, an enabled counter advances by one every P+1 clock cycles. With P = 0 it advances every cycle, and the first advance comes on the second edge after the enabling write is captured.
- R4: A tick while the counter equals the active reload value sets the counter to 0. On that edge `upd_pulse` goes high for the following cycle only, and status bit 0 is set.
- R5: With control bit 7 clear, a reload write takes effect immediately for the next comparison.
- R6: With control bit 7 set, a reload write takes effect only after the next update event. The prescale value likewise takes effect only at an update event.
- R7: With control bit 3 set, the wrap clears control bit 0, and the counter then stays at 0.
- R8: With control bit 3 clear, the counter keeps counting after a wrap.
- R9: Writing 1 to command bit 0 resets the counter and the prescaler to 0, loads the reload and prescale values into use, pulses `upd_pulse` and sets status bit 0. It does not change control bit 0.
- R10: While `dbg_halt` is high and control bit 1 is set, the counter and prescaler hold their values. With control bit 1 clear, `dbg_halt` has no effect.
- R11: Status bit 0 is sticky. Writing 0 to it clears it, and writing 1 leaves it unchanged. An update event in the same cycle as a clear takes priority.
- R12: Software can write the counter register directly, and the written value reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, captured at the rising edge |
| bus_addr | input | 3 | Word register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| dbg_halt | input | 1 | Debug halt request |
| upd_pulse | output | 1 | One-cycle pulse per update event |
| upd_flag | output | 1 | Sticky update flag (status bit 0) |

## Verification
The counter is read back on every cycle in several setups:
- Divide-by-one counting runs with direct and with buffered reload. A reload change is made in the middle of a count, which shows whether the new limit lands at once or only after the following wrap.
- A divide-by-three run shows that the prescale value is loaded only through an update event and separates tick spacing from counter spacing.
- One-pulse and free-running runs show whether the enable survives the wrap.
- Halted runs with and without the freeze option show whether the stall depends on that bit.
- A command write with a nonzero counter separates a forced restart from a natural wrap.

// File: rtl/timer_pkg.sv
// Package: shared register offsets and control-bit positions for the timer.
// Assumes a word-addressed register bus with a 3-bit address.
package timer_pkg;
    localparam int ADDR_BITS = 3;

    localparam logic [ADDR_BITS-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_BITS-1:0] A_STAT  = 3'd1;
    localparam logic [ADDR_BITS-1:0] A_RELD  = 3'd2;
    localparam logic [ADDR_BITS-1:0] A_PSCL  = 3'd3;
    localparam logic [ADDR_BITS-1:0] A_CNT   = 3'd4;
    localparam logic [ADDR_BITS-1:0] A_CMD   = 3'd5;

    localparam int B_EN     = 0;
    localparam int B_FREEZE = 1;
    localparam int B_ONESHT = 3;
    localparam int B_BUFRLD = 7;

    typedef struct packed {
        logic bufrld;
        logic onesht;
        logic freeze;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
// Module: register file of the timer. Holds control, status, reload preload and
// prescale preload, decodes command and counter writes, drives the read mux
// and registers the update pulse. Assumes writes are single-cycle strobes.
module tmr_regs
    import timer_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = ADDR_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] cnt_val,
    input  logic          ovf,
    input  logic          uev,
    output ctrl_t         ctrl,
    output logic [DW-1:0] reld_pre,
    output logic [DW-1:0] pscl_pre,
    output logic          cmd_ug,
    output logic          cnt_we,
    output logic          pulse,
    output logic          flag,
    output logic [DW-1:0] rdata
);
    logic wr_ctrl, wr_stat, wr_reld, wr_pscl;

    // Address decode for write strobes.
    always_comb begin
        wr_ctrl = we && (addr == A_CTRL);
        wr_stat = we && (addr == A_STAT);
        wr_reld = we && (addr == A_RELD);
        wr_pscl = we && (addr == A_PSCL);
        cnt_we  = we && (addr == A_CNT);
        cmd_ug  = we && (addr == A_CMD) && wdata[0];
    end

    // Control register: bus write wins, otherwise one-pulse wrap clears enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl.en     <= wdata[B_EN];
            ctrl.freeze <= wdata[B_FREEZE];
            ctrl.onesht <= wdata[B_ONESHT];
            ctrl.bufrld <= wdata[B_BUFRLD];
        end else if (ovf && ctrl.onesht) begin
            ctrl.en <= 1'b0;
        end
    end

    // Reload and prescale preload registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reld_pre <= '0;
            pscl_pre <= '0;
        end else begin
            if (wr_reld) reld_pre <= wdata;
            if (wr_pscl) pscl_pre <= wdata;
        end
    end

    // Sticky flag: set on update, cleared by writing 0; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                    flag <= 1'b0;
        else if (uev)                  flag <= 1'b1;
        else if (wr_stat && !wdata[0]) flag <= 1'b0;
    end

    // Update pulse output, one cycle per update event.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= uev;
    end

    // Read mux; reserved control bits and unmapped addresses read zero.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[B_EN]     = ctrl.en;
                rdata[B_FREEZE] = ctrl.freeze;
                rdata[B_ONESHT] = ctrl.onesht;
                rdata[B_BUFRLD] = ctrl.bufrld;
            end
            A_STAT:  rdata[0] = flag;
            A_RELD:  rdata = reld_pre;
            A_PSCL:  rdata = pscl_pre;
            A_CNT:   rdata = cnt_val;
            default: rdata = '0;
        endcase
    end

    // R7: a one-pulse wrap without a competing control write disables the timer.
    a_r7_onesht_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && ctrl.onesht && !wr_ctrl) |=> !ctrl.en);

    // R4, R11: every update event leaves the flag set and the pulse high.
    a_r4_flag_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        uev |=> (flag && pulse));

    // R11: without an update or a clearing write, the flag holds.
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!uev && !wr_stat) |=> $stable(flag));
endmodule

// File: rtl/tmr_prescaler.sv
// Module: clock prescaler. Counts enabled cycles up to the active divider value
// and emits a one-cycle tick at the top. The active divider is loaded from its
// preload only at update events. Assumes run is already gated by halt logic.
module tmr_prescaler #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          ug,
    input  logic          uev,
    input  logic [DW-1:0] pscl_pre,
    output logic          tick
);
    logic [DW-1:0] div_act;
    logic [DW-1:0] div_cnt;

    // Tick when the divider count reaches the active value.
    always_comb tick = run && (div_cnt == div_act);

    // Active divider value, reloaded at update events.
    always_ff @(posedge clk) begin
        if (!rst_n)   div_act <= '0;
        else if (uev) div_act <= pscl_pre;
    end

    // Divider count: cleared by a command, wraps at the tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_cnt <= '0;
        else if (ug)     div_cnt <= '0;
        else if (tick)   div_cnt <= '0;
        else if (run)    div_cnt <= div_cnt + 1'b1;
    end

    // R10: a stalled prescaler holds its count.
    a_r10_psc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ug) |=> $stable(div_cnt));

    // R6: the active divider changes only through an update event.
    a_r6_psc_buffered: assert property (@(posedge clk) disable iff (!rst_n)
        !uev |=> $stable(div_act));
endmodule

// File: rtl/tmr_counter.sv
// Module: main up-counter with reload comparison. Wraps to zero on a tick at
// the active reload value and reports the update event. The reload shadow
// follows the preload directly when buffering is off, else only at updates.
module tmr_counter #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ug,
    input  logic          bufrld,
    input  logic [DW-1:0] reld_pre,
    input  logic          cnt_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cnt,
    output logic          ovf,
    output logic          uev
);
    logic [DW-1:0] reld_shd;
    logic [DW-1:0] reld_act;
    logic          at_top;

    // Active limit selection, top detect and update event.
    always_comb begin
        reld_act = bufrld ? reld_shd : reld_pre;
        at_top   = (cnt == reld_act);
        ovf      = tick && at_top;
        uev      = ovf || ug;
    end

    // Reload shadow: tracks preload unless buffered, then loads at updates.
    always_ff @(posedge clk) begin
        if (!rst_n)                reld_shd <= '0;
        else if (uev || !bufrld)   reld_shd <= reld_pre;
    end

    // Counter: command restart, then software write, then tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (ug)      cnt <= '0;
        else if (cnt_we)  cnt <= wdata;
        else if (tick)    cnt <= at_top ? '0 : cnt + 1'b1;
    end

    // R4: a tick at the top wraps the counter to zero.
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_top && !ug && !cnt_we) |=> (cnt == '0));

    // R9: a command restart zeroes the counter.
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ug |=> (cnt == '0));

    // R3: without tick, command or write, the counter holds.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ug && !cnt_we) |=> $stable(cnt));

    // R6: a buffered shadow changes only at an update event.
    a_r6_reld_buffered: assert property (@(posedge clk) disable iff (!rst_n)
        (bufrld && !uev) |=> $stable(reld_shd));
endmodule

// File: rtl/upd_timer.sv
// Module: top of the auto-reload update timer. Connects the register file,
// prescaler and counter and applies the debug-halt freeze. Assumes all inputs
// are synchronous to clk.
module upd_timer
    import timer_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = ADDR_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          dbg_halt,
    output logic          upd_pulse,
    output logic          upd_flag
);
    ctrl_t         ctrl;
    logic [DW-1:0] reld_pre, pscl_pre, cnt;
    logic          cmd_ug, cnt_we, ovf, uev, tick, run;

    // Counting runs when enabled and not frozen by a debug halt.
    always_comb run = ctrl.en && !(ctrl.freeze && dbg_halt);

    tmr_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .cnt_val(cnt), .ovf(ovf), .uev(uev),
        .ctrl(ctrl), .reld_pre(reld_pre), .pscl_pre(pscl_pre),
        .cmd_ug(cmd_ug), .cnt_we(cnt_we), .pulse(upd_pulse),
        .flag(upd_flag), .rdata(bus_rdata)
    );

    tmr_prescaler #(.DW(DW)) u_pscl (
        .clk(clk), .rst_n(rst_n), .run(run), .ug(cmd_ug), .uev(uev),
        .pscl_pre(pscl_pre), .tick(tick)
    );

    tmr_counter #(.DW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ug(cmd_ug),
        .bufrld(ctrl.bufrld), .reld_pre(reld_pre), .cnt_we(cnt_we),
        .wdata(bus_wdata), .cnt(cnt), .ovf(ovf), .uev(uev)
    );

    // R10: with freeze selected, a halted timer never ticks.
    a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.freeze && dbg_halt) |-> !tick);

    // R9: a command restart leaves the enable bit as it was.
    a_r9_keep_en: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ug && !ovf && !(bus_we && bus_addr == A_CTRL)) |=> $stable(ctrl.en));
endmodule

// File: tb/tb_upd_timer.sv
module tb_upd_timer;
    import timer_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        dbg_halt = 1'b0;
    logic        upd_pulse, upd_flag;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // Scoreboard queues: kind 0 = read data, 1 = pulse, 2 = flag.
    int          qk[$];
    logic [15:0] qe[$];
    string       qt[$];

    always #2 clk = ~clk;

    upd_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
        .upd_pulse(upd_pulse), .upd_flag(upd_flag)
    );

    // Monitor: at each falling edge pop every queued expectation and compare.
    always @(negedge clk) begin
        while (qk.size() > 0) begin
            int          k;
            logic [15:0] e, act;
            string       t;
            k = qk.pop_front();
            e = qe.pop_front();
            t = qt.pop_front();
            act = (k == 0) ? bus_rdata : (k == 1) ? {15'd0, upd_pulse} : {15'd0, upd_flag};
            vectors++;
            if (act !== e) begin
                errors++;
                $display("FAIL %s: kind %0d actual %h expected %h at %0t", t, k, act, e, $time);
            end
        end
    end

    // Driver tasks; all stimulus changes 1 ns after a rising edge.
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic chk_reg(input logic [2:0] a, input logic [15:0] e, input string t);
        bus_addr = a;
        qk.push_back(0); qe.push_back(e); qt.push_back(t);
        @(posedge clk); #1;
    endtask

    task automatic chk_pin(input int k, input logic e, input string t);
        qk.push_back(k); qe.push_back({15'd0, e}); qt.push_back(t);
    endtask

    task automatic restart(input logic [15:0] reload);
        wr(A_CTRL, 16'h0000);
        wr(A_CNT, 16'h0000);
        wr(A_RELD, reload);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk_pin(1, 1'b0, "R1 pulse");
        chk_pin(2, 1'b0, "R1 flag");
        chk_reg(A_CTRL, 16'h0000, "R1 ctrl");
        chk_reg(A_CNT,  16'h0000, "R1 cnt");
        chk_reg(A_RELD, 16'h0000, "R1 reload");
        chk_reg(A_PSCL, 16'h0000, "R1 prescale");
        chk_reg(A_STAT, 16'h0000, "R1 status");

        // R2: reserved bits read zero; enable left off
        wr(A_CTRL, 16'hFFFE);
        chk_reg(A_CTRL, 16'h008A, "R2 reserved");
        chk_reg(A_CNT,  16'h0000, "R2 not enabled");
        chk_reg(3'd6,   16'h0000, "R2 unmapped");

        // R5, R8, R3: direct reload, mid-count change takes effect at once
        restart(16'd2);
        wr(A_CTRL, 16'h0001);
        for (int i = 0; i < 3; i++) chk_reg(A_CNT, 16'(i), "R3 count");
        chk_pin(1, 1'b1, "R4 pulse at wrap");
        wr(A_RELD, 16'd6);
        for (int i = 2; i < 7; i++) chk_reg(A_CNT, 16'(i), "R5 direct reload / R8 runs on");
        chk_pin(1, 1'b1, "R5 wrap at new limit");
        chk_reg(A_CNT, 16'd0, "R4 wrapped to zero");
        chk_pin(1, 1'b0, "R4 pulse one cycle");
        chk_pin(2, 1'b1, "R4 flag set");

        // R6: buffered reload, change waits for the next wrap
        restart(16'd2);
        wr(A_CTRL, 16'h0081);
        for (int i = 0; i < 3; i++) chk_reg(A_CNT, 16'(i), "R6 count");
        chk_pin(1, 1'b1, "R6 first wrap");
        wr(A_RELD, 16'd6);
        chk_reg(A_CNT, 16'd2, "R6 old limit");
        chk_pin(1, 1'b1, "R6 wrap at old limit");
        for (int i = 0; i < 7; i++) chk_reg(A_CNT, 16'(i), "R6 new limit");
        chk_pin(1, 1'b1, "R6 wrap at new limit");

        // R3, R6: prescale 2 loaded only via command update
        restart(16'd10);
        wr(A_PSCL, 16'd2);
        wr(A_CMD, 16'h0001);
        wr(A_CTRL, 16'h0001);
        for (int i = 0; i < 7; i++) chk_reg(A_CNT, 16'(i / 3), "R3 divide by three");

        // R11, R12, R9: flag clear, counter write, command restart
        wr(A_CTRL, 16'h0000);
        wr(A_PSCL, 16'd0);
        wr(A_STAT, 16'h0000);
        chk_reg(A_STAT, 16'h0000, "R11 cleared");
        wr(A_CNT, 16'd7);
        chk_reg(A_CNT, 16'd7, "R12 written");
        wr(A_CMD, 16'h0001);
        chk_pin(1, 1'b1, "R9 pulse");
        chk_reg(A_CNT, 16'd0, "R9 counter zero");
        chk_reg(A_STAT, 16'h0001, "R9 flag");
        chk_reg(A_CTRL, 16'h0000, "R9 enable kept");
        wr(A_STAT, 16'h0001);
        chk_reg(A_STAT, 16'h0001, "R11 write one ignored");
        wr(A_STAT, 16'h0000);
        chk_reg(A_STAT, 16'h0000, "R11 write zero clears");

        // R7: one-pulse stops at the wrap
        restart(16'd3);
        wr(A_CTRL, 16'h0009);
        for (int i = 0; i < 4; i++) chk_reg(A_CNT, 16'(i), "R7 count");
        chk_pin(1, 1'b1, "R7 pulse");
        chk_reg(A_CTRL, 16'h0008, "R7 enable cleared");
        chk_pin(1, 1'b0, "R7 single pulse");
        chk_reg(A_CNT, 16'd0, "R7 stays zero");
        chk_reg(A_CNT, 16'd0, "R7 stays zero again");

        // R10: freeze on halt, then halt ignored without freeze bit
        restart(16'd100);
        wr(A_CTRL, 16'h0003);
        dbg_halt = 1'b1;
        chk_reg(A_CNT, 16'd0, "R10 frozen");
        chk_reg(A_CNT, 16'd0, "R10 frozen still");
        dbg_halt = 1'b0;
        chk_reg(A_CNT, 16'd0, "R10 resume");
        chk_reg(A_CNT, 16'd1, "R10 counting");
        wr(A_CTRL, 16'h0001);
        dbg_halt = 1'b1;
        chk_reg(A_CNT, 16'd4, "R10 halt ignored");
        chk_reg(A_CNT, 16'd5, "R10 halt ignored next");
        dbg_halt = 1'b0;

        @(posedge clk); #1;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule